// File: doc/BRIEF.md
# Flash Zero-Fill Self-Test and Bulk Erase Engine

This engine checks a page-organised serial flash from end to end and, if every page is good, wipes it. After a start pulse it works through the pages from the lowest upwards. Each page is programmed with zero bytes, the engine waits for the device to report ready, and then it reads the page back. Any byte that is not zero stops the sweep at once. The engine then reports failure and the page number, and the device is left unerased.

When every page reads back clean, the engine erases the device one block at a time and waits for ready after each block. It then finishes with the error flag clear. All flash traffic goes through a separate command sequencer. The engine hands it one opcode and three address bytes with a start pulse. During a program it supplies data bytes when the sequencer pulls them. During a read it receives bytes. It pulses a stop strobe to end any data phase, and it waits for the sequencer's completion pulse.

The time between status polls is a cycle-count parameter, so it can be sized to 5 ms at the system clock. Page count, page size, block count and the block address shift are also parameters. Their defaults are 2048 pages of 256 bytes, 256 blocks and a shift of four.

Top module: `flash_sweep`

## Requirements
- R1: A start pulse while idle raises busy on the next cycle. Busy stays high until the single-cycle done pulse, and busy is low during that pulse.
- R2: Pages are programmed in ascending order from 0 to NUM_PAGES-1 with opcode 0x82. The address is three bytes: the first two hold the page number shifted left by one as a 16-bit value, and the third is 0x00.
- R3: Every program supplies exactly PAGE_BYTES data bytes, all 0x00, one per pull. The stop strobe follows the last pull, and start and stop are never high in the same cycle.
- R4: After each program or erase completes, the engine waits at least WAIT_CYCLES cycles before each status poll (opcode 0xD7, one byte). It stops the poll after that byte and polls again after another wait until bit 7 of the byte is 1 (ready).
- R5: Once a programmed page reports ready, it is read back with opcode 0xE8 at the same address. After PAGE_BYTES zero bytes the engine stops the read and moves on to the next page.
- R6: If a read returns a nonzero byte, the stop strobe follows that byte at once. The engine then ends with fail=1 and fail_page set to that page, and it issues no further program and no erase.
- R7: When every page passes, blocks 0 to NUM_BLOCKS-1 are erased in ascending order with opcode 0x50. The address is the block number shifted left by BLOCK_SHIFT in the first two bytes, followed by a 0x00 don't-care byte. Each erase is followed by status polling.
- R8: A run in which every page passes ends with fail=0.
- R9: A start pulse clears fail and fail_page. Both then hold their values from the done pulse until the next start.
- R10: While busy, progress equals the page number during the test and the block number during the erase.
- R11: After reset, busy, done, fail, cmd_start and cmd_stop are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a test-and-erase run (pulse) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Single-cycle pulse at the end of a run |
| fail | output | 1 | Last run found a nonzero byte |
| fail_page | output | IDXW | Page that failed |
| progress | output | IDXW | Current page or block index |
| cmd_start | output | 1 | Launch a command with opcode and address |
| cmd_opcode | output | 8 | Command opcode |
| cmd_addr | output | 24 | Three address bytes, most significant sent first |
| cmd_stop | output | 1 | End the current data phase |
| cmd_done | input | 1 | Sequencer finished the command (chip select released) |
| wr_pull | input | 1 | Sequencer takes one program data byte |
| wr_data | output | 8 | Program data byte |
| rd_valid | input | 1 | A read or status byte is present |
| rd_data | input | 8 | Read or status byte |

## Verification
The bench targets a bad byte at the very first byte of page 0, at the last byte of the last page, and at a random place in between. A design with an off-by-one byte or page counter would miss the fault or report the wrong page. A design that ignored the error would go on into the erase sweep. The sequencer model keeps the device busy for a random number of polls and measures the gap before each poll. A design that reads back before ready, or polls too soon, is therefore caught. Runs back to back show whether a stale fail flag leaks into a clean run, and the erase address checks catch a wrong shift or a skipped block.

// File: rtl/flash_sweep.sv
module flash_sweep #(
  parameter int NUM_PAGES   = 2048,
  parameter int PAGE_BYTES  = 256,
  parameter int NUM_BLOCKS  = 256,
  parameter int BLOCK_SHIFT = 4,
  parameter int WAIT_CYCLES = 1250000,
  localparam int IDXW = $clog2(NUM_PAGES > NUM_BLOCKS ? NUM_PAGES : NUM_BLOCKS),
  localparam int BCW  = $clog2(PAGE_BYTES + 1),
  localparam int WCW  = $clog2(WAIT_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic [IDXW-1:0] fail_page,
  output logic [IDXW-1:0] progress,
  output logic            cmd_start,
  output logic [7:0]      cmd_opcode,
  output logic [23:0]     cmd_addr,
  output logic            cmd_stop,
  input  logic            cmd_done,
  input  logic            wr_pull,
  output logic [7:0]      wr_data,
  input  logic            rd_valid,
  input  logic [7:0]      rd_data
);
  typedef enum logic [2:0] {S_IDLE, S_PROG, S_HOLD, S_POLL, S_READ, S_ERASE} st_t;
  st_t state;
  logic [IDXW-1:0] idx;
  logic [BCW-1:0]  bcnt;
  logic [WCW-1:0]  wcnt;
  logic erasing, bad, rdy;
  logic [15:0] idx16, addr_hi;

  assign idx16    = 16'(idx);
  assign addr_hi  = (state == S_POLL) ? 16'h0000 : erasing ? (idx16 << BLOCK_SHIFT) : (idx16 << 1);
  assign cmd_addr = {addr_hi, 8'h00};
  assign progress = idx;
  assign wr_data  = 8'h00;

  always_comb begin
    case (state)
      S_PROG:  cmd_opcode = 8'h82;
      S_POLL:  cmd_opcode = 8'hD7;
      S_READ:  cmd_opcode = 8'hE8;
      S_ERASE: cmd_opcode = 8'h50;
      default: cmd_opcode = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; idx <= '0; bcnt <= '0; wcnt <= '0;
      erasing <= 1'b0; bad <= 1'b0; rdy <= 1'b0;
      busy <= 1'b0; done <= 1'b0; fail <= 1'b0; fail_page <= '0;
      cmd_start <= 1'b0; cmd_stop <= 1'b0;
    end else begin
      cmd_start <= 1'b0;
      cmd_stop  <= 1'b0;
      done      <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          busy <= 1'b1; fail <= 1'b0; fail_page <= '0;
          idx <= '0; erasing <= 1'b0; bcnt <= '0; bad <= 1'b0;
          state <= S_PROG; cmd_start <= 1'b1;
        end
        S_PROG: begin
          if (wr_pull) begin
            bcnt <= bcnt + 1'b1;
            if (bcnt == BCW'(PAGE_BYTES - 1)) cmd_stop <= 1'b1;
          end
          if (cmd_done) begin state <= S_HOLD; wcnt <= '0; end
        end
        S_HOLD: begin
          if (wcnt == WCW'(WAIT_CYCLES - 1)) begin
            state <= S_POLL; cmd_start <= 1'b1; rdy <= 1'b0;
          end else wcnt <= wcnt + 1'b1;
        end
        S_POLL: begin
          if (rd_valid) begin rdy <= rd_data[7]; cmd_stop <= 1'b1; end
          if (cmd_done) begin
            if (!rdy) begin
              state <= S_HOLD; wcnt <= '0;
            end else if (erasing) begin
              if (idx == IDXW'(NUM_BLOCKS - 1)) begin
                state <= S_IDLE; busy <= 1'b0; done <= 1'b1;
              end else begin
                idx <= idx + 1'b1; state <= S_ERASE; cmd_start <= 1'b1;
              end
            end else begin
              state <= S_READ; cmd_start <= 1'b1; bcnt <= '0; bad <= 1'b0;
            end
          end
        end
        S_READ: begin
          if (rd_valid && !bad) begin
            bcnt <= bcnt + 1'b1;
            if (rd_data != 8'h00) begin bad <= 1'b1; cmd_stop <= 1'b1; end
            else if (bcnt == BCW'(PAGE_BYTES - 1)) cmd_stop <= 1'b1;
          end
          if (cmd_done) begin
            if (bad) begin
              fail <= 1'b1; fail_page <= idx;
              state <= S_IDLE; busy <= 1'b0; done <= 1'b1;
            end else if (idx == IDXW'(NUM_PAGES - 1)) begin
              erasing <= 1'b1; idx <= '0; state <= S_ERASE; cmd_start <= 1'b1;
            end else begin
              idx <= idx + 1'b1; bcnt <= '0; state <= S_PROG; cmd_start <= 1'b1;
            end
          end
        end
        S_ERASE: if (cmd_done) begin state <= S_HOLD; wcnt <= '0; end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_sweep_chk.sv
module flash_sweep_chk #(
  parameter int NUM_PAGES = 2048,
  parameter int IDXW = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            fail,
  input logic [IDXW-1:0] fail_page,
  input logic [IDXW-1:0] progress,
  input logic            cmd_start,
  input logic [7:0]      cmd_opcode,
  input logic            cmd_stop
);
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R1
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> (busy && !fail)); // R9
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> ($stable(fail) && $stable(fail_page))); // R9
  AST_ONE_CMD_EVENT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({cmd_start, cmd_stop})); // R3
  AST_PROGRESS_RANGE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (int'(progress) < NUM_PAGES)); // R10
  AST_ERASE_ONLY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (cmd_start && cmd_opcode == 8'h50) |-> !fail); // R6
endmodule

bind flash_sweep flash_sweep_chk #(.NUM_PAGES(NUM_PAGES), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
  .fail_page(fail_page), .progress(progress), .cmd_start(cmd_start),
  .cmd_opcode(cmd_opcode), .cmd_stop(cmd_stop)
);

// File: tb/sim_flash_sweep.sv
`timescale 1ns/1ps
module sim_flash_sweep;
  localparam int NP = 16, PB = 8, NB = 4, SH = 4, W = 6, IW = 4;
  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, fail, cmd_start, cmd_stop;
  logic [IW-1:0] fail_page, progress;
  logic [7:0] cmd_opcode, wr_data, rd_data;
  logic [23:0] cmd_addr;
  logic cmd_done = 0, wr_pull = 0, rd_valid = 0;
  int checks = 0, fails = 0, cyc = 0;
  int exp_op, mode, pg, blk, busy_left, fault_pg, fault_by, n_erase, n_prog, last_done;

  flash_sweep #(.NUM_PAGES(NP), .PAGE_BYTES(PB), .NUM_BLOCKS(NB), .BLOCK_SHIFT(SH), .WAIT_CYCLES(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
    .fail_page(fail_page), .progress(progress), .cmd_start(cmd_start), .cmd_opcode(cmd_opcode),
    .cmd_addr(cmd_addr), .cmd_stop(cmd_stop), .cmd_done(cmd_done), .wr_pull(wr_pull),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  function automatic logic [23:0] page_addr(int p); return {16'(p) << 1, 8'h00}; endfunction
  function automatic logic [23:0] blk_addr(int b); return {16'(b) << SH, 8'h00}; endfunction
  function automatic string op_req(int op);
    case (op) 8'h82: return "R2"; 8'hE8: return "R5"; 8'hD7: return "R4"; default: return "R7"; endcase
  endfunction

  task automatic serve();
    int op, n, want;
    bit hit;
    logic [23:0] a;
    op = int'(cmd_opcode); a = cmd_addr;
    chk(op == exp_op, op_req(op), op, exp_op);
    case (op)
      8'h82: begin
        chk(a == page_addr(pg), "R2", int'(a), int'(page_addr(pg)));
        chk(int'(progress) == pg, "R10", int'(progress), pg);
        n = 0; hit = 0;
        forever begin
          @(negedge clk); wr_pull = 1;
          if (wr_data != 8'h00) hit = 1;
          @(negedge clk); wr_pull = 0; n++;
          if (cmd_stop || n > PB + 2) break;
        end
        chk(n == PB, "R3", n, PB);
        chk(!hit, "R3", int'(hit), 0);
        busy_left = $urandom % 4; mode = 0; exp_op = 8'hD7; n_prog++;
      end
      8'hE8: begin
        chk(a == page_addr(pg), "R5", int'(a), int'(page_addr(pg)));
        n = 0; hit = 0;
        want = (pg == fault_pg) ? fault_by + 1 : PB;
        forever begin
          @(negedge clk); rd_valid = 1;
          if (pg == fault_pg && n == fault_by) begin rd_data = 8'(($urandom % 255) + 1); hit = 1; end
          else rd_data = 8'h00;
          @(negedge clk); rd_valid = 0; n++;
          if (cmd_stop || n > PB + 2) break;
        end
        chk(n == want, hit ? "R6" : "R5", n, want);
        if (hit) exp_op = -1;
        else if (pg == NP - 1) begin exp_op = 8'h50; blk = 0; end
        else begin pg++; exp_op = 8'h82; end
      end
      8'hD7: begin
        chk(cyc - last_done >= W, "R4", cyc - last_done, W);
        @(negedge clk); rd_valid = 1;
        rd_data = (busy_left == 0) ? (8'h80 | 8'($urandom % 128)) : 8'($urandom % 128);
        @(negedge clk); rd_valid = 0;
        chk(cmd_stop == 1, "R4", int'(cmd_stop), 1);
        if (busy_left == 0) begin
          if (mode == 0) exp_op = 8'hE8;
          else begin blk++; exp_op = (blk == NB) ? -1 : 8'h50; end
        end else begin busy_left--; exp_op = 8'hD7; end
      end
      8'h50: begin
        chk(a == blk_addr(blk), "R7", int'(a), int'(blk_addr(blk)));
        chk(int'(progress) == blk, "R10", int'(progress), blk);
        @(negedge clk);
        busy_left = $urandom % 4; mode = 1; exp_op = 8'hD7; n_erase++;
      end
      default: ;
    endcase
    cmd_done = 1; last_done = cyc;
  endtask

  initial begin
    forever begin
      @(negedge clk); cmd_done = 0;
      if (cmd_start) serve();
    end
  end

  task automatic run(int fp, int fb);
    int t;
    logic fsave;
    logic [IW-1:0] psave;
    bit ef;
    ef = (fp >= 0);
    fault_pg = fp; fault_by = fb; pg = 0; blk = 0; exp_op = 8'h82;
    n_erase = 0; n_prog = 0; last_done = cyc;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy == 1, "R1", int'(busy), 1);
    chk(fail == 0, "R9", int'(fail), 0);
    t = 0;
    while (!done && t < 50000) begin @(negedge clk); t++; end
    chk(t < 50000, "R1", t, 50000);
    chk(busy == 0, "R1", int'(busy), 0);
    chk(fail == ef, ef ? "R6" : "R8", int'(fail), int'(ef));
    if (ef) begin
      chk(int'(fail_page) == fp, "R6", int'(fail_page), fp);
      chk(n_erase == 0, "R6", n_erase, 0);
      chk(n_prog == fp + 1, "R2", n_prog, fp + 1);
    end else begin
      chk(n_erase == NB, "R7", n_erase, NB);
      chk(n_prog == NP, "R2", n_prog, NP);
    end
    fsave = fail; psave = fail_page;
    repeat (20) @(negedge clk);
    chk(fail == fsave && fail_page == psave, "R9", int'(fail_page), int'(psave));
    chk(busy == 0 && !cmd_start, "R9", int'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rd_data = 8'h00;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && fail == 0, "R11", int'({busy, done, fail}), 0);
    chk(cmd_start == 0 && cmd_stop == 0, "R11", int'({cmd_start, cmd_stop}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run(-1, 0);
    run(1 + int'($urandom % (NP - 2)), int'($urandom % PB));
    run(0, 0);
    run(NP - 1, PB - 1);
    run(-1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule